// File: doc/BRIEF.md
# Multi-Slot Pipeline Resource Allocator with Selective Squash

A pipeline resource is shared by in-flight instructions through a fixed pool of service slots. An instruction asks for service by presenting its thread id, a sequence number, a stage number and a command. The block hands out free slot indices from an ordered queue and returns indices to that queue when slots are freed. It answers each request one cycle later with either a grant, carrying the slot index, or a deny. Each granted slot starts a fixed-latency service timer. When the timer expires, the slot raises a one-cycle completion pulse and then holds a sticky done flag.

An instruction that already owns a slot and asks again keeps that slot. Its timer is restarted, and the response marks the grant as a reuse. A squash names a thread and a sequence number. It frees every slot of that thread that is strictly younger than the named sequence number and cancels the pending timers of those slots. Deactivating a thread is done with a squash whose sequence number is zero. An explicit release returns a single finished slot to the pool. The block reports free and used slot counts every cycle.

Top module: `slot_pool_alloc`

## Requirements
- R1: After reset all slots are free: `avail_cnt` = NUM_SLOTS, `inuse_cnt` = 0, and `slot_busy`, `slot_done`, `done_pulse` and the response bits are all zero.
- R2: A new allocation takes the index at the head of the free queue. Right after reset the queue holds 0, 1, …, NUM_SLOTS-1, so successive new grants return slots 0, 1, 2, … in that order.
- R3: Freed indices are appended at the tail of the free queue. When several slots are freed in one cycle (squash and release together), they are appended in ascending slot index order.
- R4: A request whose thread id and sequence number match a busy slot that is not freed in that cycle takes no new slot. It is granted that slot with `rsp_reuse`=1, its timer restarts and its done flag clears. `rsp_stage` and `rsp_cmd` report the values stored when the slot was first allocated.
- R5: A request from an instruction that owns no slot is denied (`rsp_deny`=1, `rsp_grant`=0) when the free queue is empty at the start of that cycle. A denied request changes no slot state and no count.
- R6: With SERVICE_LAT = 0, `done_pulse` and `slot_done` rise in the same cycle as the grant response. With SERVICE_LAT = L ≥ 1, they rise L cycles after the grant response. `done_pulse` lasts one cycle; `slot_done` stays set until the slot is freed or restarted.
- R7: A squash frees every busy slot whose thread id equals `sq_tid` and whose sequence number is strictly greater than `sq_seq`. Its timer is cancelled, so no later completion pulse appears. Slots of other threads, and slots with an equal or smaller sequence number, are untouched.
- R8: A squash with `sq_seq` = 0 deactivates a thread: every slot of that thread whose sequence number is nonzero is freed.
- R9: A release of a busy slot clears its busy and done flags and returns it to the free queue. A release of a slot that is not busy is ignored.
- R10: `avail_cnt` equals the free-queue length, `inuse_cnt` equals NUM_SLOTS minus that length, and `inuse_cnt` equals the number of set `slot_busy` bits.
- R11: A request in the same cycle as a squash that would cover it (same thread, sequence number greater than `sq_seq`) is denied.
- R12: The response is registered. A request in cycle k yields exactly one of `rsp_grant` or `rsp_deny` in cycle k+1. Both are 0 in a cycle that follows no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Service request present |
| req_tid | input | TID_W | Requesting thread id |
| req_seq | input | SEQ_W | Requesting sequence number |
| req_stage | input | STAGE_W | Pipeline stage of the request |
| req_cmd | input | CMD_W | Command for the resource |
| sq_valid | input | 1 | Squash present |
| sq_tid | input | TID_W | Thread to squash |
| sq_seq | input | SEQ_W | Entries strictly younger than this are squashed |
| rel_valid | input | 1 | Release a slot |
| rel_slot | input | $clog2(NUM_SLOTS) | Slot to release |
| rsp_grant | output | 1 | Request granted (registered) |
| rsp_deny | output | 1 | Request denied (registered) |
| rsp_reuse | output | 1 | Grant reused an owned slot |
| rsp_slot | output | $clog2(NUM_SLOTS) | Granted slot index |
| rsp_stage | output | STAGE_W | Stored stage of the granted slot |
| rsp_cmd | output | CMD_W | Stored command of the granted slot |
| slot_busy | output | NUM_SLOTS | Per-slot occupied flags |
| slot_done | output | NUM_SLOTS | Per-slot sticky completion flags |
| done_pulse | output | NUM_SLOTS | Per-slot one-cycle completion pulses |
| avail_cnt | output | $clog2(NUM_SLOTS+1) | Free-queue length |
| inuse_cnt | output | $clog2(NUM_SLOTS+1) | Slots in use |

## Verification
The bench builds two copies of the block with four slots, 2-bit thread ids and 4-bit sequence numbers. One copy has a service latency of two cycles and the other a latency of zero, so both timer variants and the immediate-completion path see the same stimulus. Four slots make it possible to reach a full pool, a deny, queue wrap-around and multi-slot squashes in a few cycles. A long pseudo-random sweep draws sequence numbers from a small range, so re-requests, same-cycle squash/request collisions and squash-plus-release orderings occur often.

// File: rtl/slot_pool_pkg.sv
package slot_pool_pkg;

    // Add an offset to a circular index; both inputs are below n.
    function automatic int wrap_idx(int base, int off, int n);
        int s;
        s = base + off;
        return (s >= n) ? (s - n) : s;
    endfunction

endpackage

// File: rtl/slot_pool_freeq.sv
module slot_pool_freeq
    import slot_pool_pkg::*;
#(
    parameter int N = 4,
    localparam int IW   = $clog2(N),
    localparam int CNTW = $clog2(N + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pop,
    input  logic [N-1:0]    push_mask,
    output logic [IW-1:0]   head_idx,
    output logic [CNTW-1:0] count
);

    typedef struct {
        logic [IW-1:0]   ent [N];
        logic [IW-1:0]   head;
        logic [CNTW-1:0] cnt;
    } fq_t;

    fq_t s_d, s_q;

    always_comb begin
        int tail;
        int k;
        s_d  = s_q;
        tail = wrap_idx(int'(s_q.head), int'(s_q.cnt), N);
        k    = 0;
        // freed indices go to the tail, lowest index first
        for (int i = 0; i < N; i++) begin
            if (push_mask[i]) begin
                s_d.ent[wrap_idx(tail, k, N)] = IW'(i);
                k++;
            end
        end
        if (pop) begin
            s_d.head = IW'(wrap_idx(int'(s_q.head), 1, N));
        end
        s_d.cnt = CNTW'(int'(s_q.cnt) - (pop ? 1 : 0) + k);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                s_q.ent[i] <= IW'(i);
            end
            s_q.head <= '0;
            s_q.cnt  <= CNTW'(N);
        end else begin
            s_q <= s_d;
        end
    end

    assign head_idx = s_q.ent[s_q.head];
    assign count    = s_q.cnt;

endmodule

// File: rtl/slot_pool_timer.sv
module slot_pool_timer #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cancel,
    output logic done_flag,
    output logic done_pulse
);

    generate
        if (LAT == 0) begin : g_zero
            typedef struct packed {
                logic done;
                logic pulse;
            } tz_t;
            tz_t s_d, s_q;

            always_comb begin
                s_d       = s_q;
                s_d.pulse = start;
                if (cancel) begin
                    s_d.done = 1'b0;
                end else if (start) begin
                    s_d.done = 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) s_q <= '0;
                else        s_q <= s_d;
            end

            assign done_flag  = s_q.done;
            assign done_pulse = s_q.pulse;
        end else begin : g_count
            localparam int CW = $clog2(LAT + 1);
            typedef struct packed {
                logic          active;
                logic [CW-1:0] cnt;
                logic          done;
                logic          pulse;
            } tc_t;
            tc_t s_d, s_q;

            always_comb begin
                s_d       = s_q;
                s_d.pulse = 1'b0;
                if (cancel) begin
                    s_d.active = 1'b0;
                    s_d.done   = 1'b0;
                end else if (start) begin
                    s_d.active = 1'b1;
                    s_d.cnt    = CW'(LAT);
                    s_d.done   = 1'b0;
                end else if (s_q.active) begin
                    if (s_q.cnt == CW'(1)) begin
                        s_d.active = 1'b0;
                        s_d.done   = 1'b1;
                        s_d.pulse  = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt - CW'(1);
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) s_q <= '0;
                else        s_q <= s_d;
            end

            assign done_flag  = s_q.done;
            assign done_pulse = s_q.pulse;
        end
    endgenerate

endmodule

// File: rtl/slot_pool_alloc.sv
module slot_pool_alloc
    import slot_pool_pkg::*;
#(
    parameter int NUM_SLOTS   = 4,
    parameter int SERVICE_LAT = 2,
    parameter int TID_W       = 2,
    parameter int SEQ_W       = 8,
    parameter int STAGE_W     = 3,
    parameter int CMD_W       = 4,
    localparam int IW   = $clog2(NUM_SLOTS),
    localparam int CNTW = $clog2(NUM_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [TID_W-1:0]     req_tid,
    input  logic [SEQ_W-1:0]     req_seq,
    input  logic [STAGE_W-1:0]   req_stage,
    input  logic [CMD_W-1:0]     req_cmd,
    input  logic                 sq_valid,
    input  logic [TID_W-1:0]     sq_tid,
    input  logic [SEQ_W-1:0]     sq_seq,
    input  logic                 rel_valid,
    input  logic [IW-1:0]        rel_slot,
    output logic                 rsp_grant,
    output logic                 rsp_deny,
    output logic                 rsp_reuse,
    output logic [IW-1:0]        rsp_slot,
    output logic [STAGE_W-1:0]   rsp_stage,
    output logic [CMD_W-1:0]     rsp_cmd,
    output logic [NUM_SLOTS-1:0] slot_busy,
    output logic [NUM_SLOTS-1:0] slot_done,
    output logic [NUM_SLOTS-1:0] done_pulse,
    output logic [CNTW-1:0]      avail_cnt,
    output logic [CNTW-1:0]      inuse_cnt
);

    localparam int N = NUM_SLOTS;

    typedef struct {
        logic [N-1:0]       valid;
        logic [TID_W-1:0]   tid   [N];
        logic [SEQ_W-1:0]   seq   [N];
        logic [STAGE_W-1:0] stage [N];
        logic [CMD_W-1:0]   cmd   [N];
        logic               grant;
        logic               deny;
        logic               reuse;
        logic [IW-1:0]      slot;
        logic [STAGE_W-1:0] rstage;
        logic [CMD_W-1:0]   rcmd;
    } st_t;

    st_t s_d, s_q;

    logic [N-1:0]    sq_hit, rel_hit, free_mask, start_vec;
    logic            req_killed, own_any, take, fq_pop;
    logic [IW-1:0]   own_idx, pick, fq_head;
    logic [CNTW-1:0] fq_cnt;

    // Hit detection: squash before release before request
    always_comb begin
        for (int i = 0; i < N; i++) begin
            sq_hit[i]  = sq_valid && s_q.valid[i] && (s_q.tid[i] == sq_tid)
                         && (s_q.seq[i] > sq_seq);
            rel_hit[i] = rel_valid && (rel_slot == IW'(i)) && s_q.valid[i]
                         && !sq_hit[i];
        end
        free_mask  = sq_hit | rel_hit;
        req_killed = req_valid && sq_valid && (req_tid == sq_tid) && (req_seq > sq_seq);
        own_any    = 1'b0;
        own_idx    = '0;
        for (int i = 0; i < N; i++) begin
            if (s_q.valid[i] && !free_mask[i] && (s_q.tid[i] == req_tid)
                && (s_q.seq[i] == req_seq)) begin
                own_any = 1'b1;
                own_idx = IW'(i);
            end
        end
        take   = req_valid && !req_killed && (own_any || (fq_cnt != '0));
        fq_pop = take && !own_any;
        pick   = own_any ? own_idx : fq_head;
        for (int i = 0; i < N; i++) begin
            start_vec[i] = take && (pick == IW'(i));
        end
    end

    // Next-state computation
    always_comb begin
        s_d       = s_q;
        s_d.valid = s_q.valid & ~free_mask;
        if (fq_pop) begin
            s_d.valid[fq_head] = 1'b1;
            s_d.tid[fq_head]   = req_tid;
            s_d.seq[fq_head]   = req_seq;
            s_d.stage[fq_head] = req_stage;
            s_d.cmd[fq_head]   = req_cmd;
        end
        s_d.grant  = take;
        s_d.deny   = req_valid && !take;
        s_d.reuse  = take && own_any;
        s_d.slot   = take ? pick : '0;
        s_d.rstage = '0;
        s_d.rcmd   = '0;
        if (take) begin
            s_d.rstage = own_any ? s_q.stage[own_idx] : req_stage;
            s_d.rcmd   = own_any ? s_q.cmd[own_idx]   : req_cmd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.valid  <= '0;
            s_q.grant  <= 1'b0;
            s_q.deny   <= 1'b0;
            s_q.reuse  <= 1'b0;
            s_q.slot   <= '0;
            s_q.rstage <= '0;
            s_q.rcmd   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    slot_pool_freeq #(.N(N)) freeq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop       (fq_pop),
        .push_mask (free_mask),
        .head_idx  (fq_head),
        .count     (fq_cnt)
    );

    generate
        for (genvar g = 0; g < N; g++) begin : g_timer
            slot_pool_timer #(.LAT(SERVICE_LAT)) timer_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .start      (start_vec[g]),
                .cancel     (free_mask[g]),
                .done_flag  (slot_done[g]),
                .done_pulse (done_pulse[g])
            );
        end
    endgenerate

    assign rsp_grant = s_q.grant;
    assign rsp_deny  = s_q.deny;
    assign rsp_reuse = s_q.reuse;
    assign rsp_slot  = s_q.slot;
    assign rsp_stage = s_q.rstage;
    assign rsp_cmd   = s_q.rcmd;
    assign slot_busy = s_q.valid;
    assign avail_cnt = fq_cnt;
    assign inuse_cnt = CNTW'(N) - fq_cnt;

endmodule

// File: rtl/slot_pool_alloc_chk.sv
module slot_pool_alloc_chk #(
    parameter int N    = 4,
    parameter int IW   = 2,
    parameter int CNTW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            rsp_grant,
    input logic            rsp_deny,
    input logic            rsp_reuse,
    input logic [IW-1:0]   rsp_slot,
    input logic [N-1:0]    slot_busy,
    input logic [N-1:0]    slot_done,
    input logic [N-1:0]    done_pulse,
    input logic [CNTW-1:0] avail_cnt,
    input logic [CNTW-1:0] inuse_cnt
);

    a_r10_busy_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(slot_busy) == int'(inuse_cnt));

    a_r12_req_answered: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_grant ^ rsp_deny));

    a_r12_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_grant || rsp_deny) |-> $past(req_valid));

    a_r5_full_no_new_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_grant && !rsp_reuse) |-> ($past(avail_cnt) != '0));

    a_r2_granted_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_grant |-> slot_busy[rsp_slot]);

    a_r6_pulse_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse & ~slot_done) == '0);

    a_r9_done_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_done & ~slot_busy) == '0);

endmodule

bind slot_pool_alloc slot_pool_alloc_chk #(
    .N(NUM_SLOTS), .IW(IW), .CNTW(CNTW)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .rsp_grant  (rsp_grant),
    .rsp_deny   (rsp_deny),
    .rsp_reuse  (rsp_reuse),
    .rsp_slot   (rsp_slot),
    .slot_busy  (slot_busy),
    .slot_done  (slot_done),
    .done_pulse (done_pulse),
    .avail_cnt  (avail_cnt),
    .inuse_cnt  (inuse_cnt)
);

// File: tb/slot_pool_alloc_tb_top.sv
module slot_pool_alloc_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N    = 4;
    localparam int TW   = 2;
    localparam int SW   = 4;
    localparam int STW  = 2;
    localparam int CMW  = 3;
    localparam int IW   = 2;
    localparam int CNTW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic           req_valid = 0;
    logic [TW-1:0]  req_tid = 0;
    logic [SW-1:0]  req_seq = 0;
    logic [STW-1:0] req_stage = 0;
    logic [CMW-1:0] req_cmd = 0;
    logic           sq_valid = 0;
    logic [TW-1:0]  sq_tid = 0;
    logic [SW-1:0]  sq_seq = 0;
    logic           rel_valid = 0;
    logic [IW-1:0]  rel_slot = 0;

    logic            o_grant [2];
    logic            o_deny  [2];
    logic            o_reuse [2];
    logic [IW-1:0]   o_slot  [2];
    logic [STW-1:0]  o_stage [2];
    logic [CMW-1:0]  o_cmd   [2];
    logic [N-1:0]    o_busy  [2];
    logic [N-1:0]    o_done  [2];
    logic [N-1:0]    o_pulse [2];
    logic [CNTW-1:0] o_avail [2];
    logic [CNTW-1:0] o_inuse [2];

    slot_pool_alloc #(.NUM_SLOTS(N), .SERVICE_LAT(2), .TID_W(TW), .SEQ_W(SW),
                      .STAGE_W(STW), .CMD_W(CMW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tid(req_tid),
        .req_seq(req_seq), .req_stage(req_stage), .req_cmd(req_cmd),
        .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
        .rel_valid(rel_valid), .rel_slot(rel_slot),
        .rsp_grant(o_grant[0]), .rsp_deny(o_deny[0]), .rsp_reuse(o_reuse[0]),
        .rsp_slot(o_slot[0]), .rsp_stage(o_stage[0]), .rsp_cmd(o_cmd[0]),
        .slot_busy(o_busy[0]), .slot_done(o_done[0]), .done_pulse(o_pulse[0]),
        .avail_cnt(o_avail[0]), .inuse_cnt(o_inuse[0]));

    slot_pool_alloc #(.NUM_SLOTS(N), .SERVICE_LAT(0), .TID_W(TW), .SEQ_W(SW),
                      .STAGE_W(STW), .CMD_W(CMW)) dut_z_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tid(req_tid),
        .req_seq(req_seq), .req_stage(req_stage), .req_cmd(req_cmd),
        .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
        .rel_valid(rel_valid), .rel_slot(rel_slot),
        .rsp_grant(o_grant[1]), .rsp_deny(o_deny[1]), .rsp_reuse(o_reuse[1]),
        .rsp_slot(o_slot[1]), .rsp_stage(o_stage[1]), .rsp_cmd(o_cmd[1]),
        .slot_busy(o_busy[1]), .slot_done(o_done[1]), .done_pulse(o_pulse[1]),
        .avail_cnt(o_avail[1]), .inuse_cnt(o_inuse[1]));

    int n_checks = 0;
    int n_fails  = 0;

    // expected-state model, index 0: latency 2, index 1: latency 0
    bit mv    [2][N];
    int mtid  [2][N];
    int mseq  [2][N];
    int mstg  [2][N];
    int mcmd  [2][N];
    int mt    [2][N];
    bit mdone [2][N];
    bit mpul  [2][N];
    int fq    [2][N];
    int fh    [2];
    int fc    [2];
    bit eg [2], ed [2], er [2];
    int es [2], estg [2], ecmd [2];

    task automatic model_reset();
        for (int u = 0; u < 2; u++) begin
            for (int i = 0; i < N; i++) begin
                mv[u][i] = 0; mt[u][i] = 0; mdone[u][i] = 0; mpul[u][i] = 0;
                mtid[u][i] = 0; mseq[u][i] = 0; mstg[u][i] = 0; mcmd[u][i] = 0;
                fq[u][i] = i;
            end
            fh[u] = 0; fc[u] = N;
            eg[u] = 0; ed[u] = 0; er[u] = 0; es[u] = 0; estg[u] = 0; ecmd[u] = 0;
        end
    endtask

    task automatic model_step(int u, int lat);
        bit fm [N];
        bit killed, own;
        int oi, slot, k, tail;
        killed = req_valid && sq_valid && (req_tid == sq_tid) && (req_seq > sq_seq);
        for (int i = 0; i < N; i++) begin
            bit sh;
            sh = sq_valid && mv[u][i] && (mtid[u][i] == int'(sq_tid)) && (mseq[u][i] > int'(sq_seq));
            fm[i] = sh || (rel_valid && (int'(rel_slot) == i) && mv[u][i] && !sh);
        end
        own = 0; oi = 0;
        for (int i = 0; i < N; i++)
            if (mv[u][i] && !fm[i] && mtid[u][i] == int'(req_tid) && mseq[u][i] == int'(req_seq)) begin
                own = 1; oi = i;
            end
        for (int i = 0; i < N; i++) begin
            mpul[u][i] = 0;
            if (fm[i]) begin
                mv[u][i] = 0; mt[u][i] = 0; mdone[u][i] = 0;
            end else if (mt[u][i] > 0) begin
                mt[u][i]--;
                if (mt[u][i] == 0) begin mdone[u][i] = 1; mpul[u][i] = 1; end
            end
        end
        tail = (fh[u] + fc[u]) % N;
        eg[u] = 0; ed[u] = 0; er[u] = 0; es[u] = 0; estg[u] = 0; ecmd[u] = 0;
        slot = 0;
        if (req_valid && !killed && own) begin
            eg[u] = 1; er[u] = 1; slot = oi;
            estg[u] = mstg[u][oi]; ecmd[u] = mcmd[u][oi];
        end else if (req_valid && !killed && fc[u] > 0) begin
            eg[u] = 1; slot = fq[u][fh[u]];
            fh[u] = (fh[u] + 1) % N; fc[u]--;
            mv[u][slot] = 1; mtid[u][slot] = int'(req_tid); mseq[u][slot] = int'(req_seq);
            mstg[u][slot] = int'(req_stage); mcmd[u][slot] = int'(req_cmd);
            estg[u] = int'(req_stage); ecmd[u] = int'(req_cmd);
        end else if (req_valid) begin
            ed[u] = 1;
        end
        if (eg[u]) begin
            es[u] = slot;
            if (lat == 0) begin
                mdone[u][slot] = 1; mpul[u][slot] = 1; mt[u][slot] = 0;
            end else begin
                mdone[u][slot] = 0; mpul[u][slot] = 0; mt[u][slot] = lat;
            end
        end
        k = 0;
        for (int i = 0; i < N; i++)
            if (fm[i]) begin fq[u][(tail + k) % N] = i; k++; end
        fc[u] += k;
    endtask

    function automatic logic [31:0] pack_exp(int u);
        logic [N-1:0] b, d, p;
        for (int i = 0; i < N; i++) begin b[i] = mv[u][i]; d[i] = mdone[u][i]; p[i] = mpul[u][i]; end
        return {4'd0, eg[u], ed[u], er[u], IW'(es[u]), STW'(estg[u]), CMW'(ecmd[u]),
                b, d, p, CNTW'(fc[u]), CNTW'(N - fc[u])};
    endfunction

    function automatic logic [31:0] pack_act(int u);
        return {4'd0, o_grant[u], o_deny[u], o_reuse[u], o_slot[u], o_stage[u], o_cmd[u],
                o_busy[u], o_done[u], o_pulse[u], o_avail[u], o_inuse[u]};
    endfunction

    task automatic compare(string tag);
        for (int u = 0; u < 2; u++) begin
            n_checks++;
            if (pack_act(u) !== pack_exp(u)) begin
                n_fails++;
                $display("FAIL %s lat%0d actual=%h expected=%h", tag, (u == 0) ? 2 : 0,
                         pack_act(u), pack_exp(u));
            end
        end
    endtask

    task automatic cyc(string tag, bit rv, int rt, int rs, int rg, int rc,
                       bit sv, int st, int ss, bit lv, int ls);
        @(negedge clk);
        req_valid = rv; req_tid = TW'(rt); req_seq = SW'(rs); req_stage = STW'(rg); req_cmd = CMW'(rc);
        sq_valid = sv; sq_tid = TW'(st); sq_seq = SW'(ss);
        rel_valid = lv; rel_slot = IW'(ls);
        @(posedge clk);
        model_step(0, 2);
        model_step(1, 0);
        #1;
        compare(tag);
        req_valid = 0; sq_valid = 0; rel_valid = 0;
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        compare("R1 reset state");
        idle("R1 idle after reset", 1);
        // R2: ascending allocation from reset; R6: completion timing
        cyc("R2 alloc 0", 1, 0, 1, 1, 1, 0, 0, 0, 0, 0);
        cyc("R2 alloc 1", 1, 0, 2, 2, 2, 0, 0, 0, 0, 0);
        cyc("R2 alloc 2", 1, 0, 3, 3, 3, 0, 0, 0, 0, 0);
        cyc("R2 alloc 3", 1, 0, 4, 0, 4, 0, 0, 0, 0, 0);
        idle("R6 latency", 3);
        cyc("R5 deny when full", 1, 1, 9, 1, 5, 0, 0, 0, 0, 0);
        idle("R5 no change", 1);
        cyc("R4 reuse owned slot", 1, 0, 2, 3, 7, 0, 0, 0, 0, 0);
        idle("R4 R6 restart", 3);
        cyc("R9 release 2", 0, 0, 0, 0, 0, 0, 0, 0, 1, 2);
        cyc("R9 release idle slot ignored", 0, 0, 0, 0, 0, 0, 0, 0, 1, 2);
        cyc("R9 release 0", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        cyc("R3 tail order a", 1, 2, 3, 1, 1, 0, 0, 0, 0, 0);
        cyc("R3 tail order b", 1, 2, 4, 2, 2, 0, 0, 0, 0, 0);
        cyc("R7 squash younger", 0, 0, 0, 0, 0, 1, 0, 2, 0, 0);
        idle("R7 no pulse after cancel", 3);
        cyc("R8 deactivate thread", 0, 0, 0, 0, 0, 1, 2, 0, 0, 0);
        cyc("R3 order after squash a", 1, 3, 1, 1, 1, 0, 0, 0, 0, 0);
        cyc("R11 squashed request denied", 1, 3, 5, 1, 1, 1, 3, 2, 0, 0);
        cyc("R3 squash plus release", 0, 0, 0, 0, 0, 1, 3, 0, 1, 1);
        cyc("R3 order after squash b", 1, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R3 order after squash c", 1, 1, 2, 0, 0, 0, 0, 0, 0, 0);
        idle("R6 settle", 3);
        // R10 / R12 sweep over dense, colliding stimulus
        lf = 32'h1234_5678;
        for (int c = 0; c < 3000; c++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            cyc("R10 R12 sweep", lf[0] | lf[1], int'(lf[3:2]), int'(lf[6:4]), int'(lf[8:7]),
                int'(lf[11:9]), lf[14:12] == 3'd0, int'(lf[16:15]), int'(lf[18:17]),
                lf[20:19] == 2'd0, int'(lf[22:21]));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule